// File: doc/BRIEF.md
# Split Trigger Distributor

This block sits between a trigger source and two detector readout branches: an inner branch and an outer branch. Each request from the source comes as a strobe with a class code: low-energy, high-energy or outer. The block decides which branches get a trigger pulse. A low-energy request goes only to the inner branch. High-energy and outer requests go to both branches. Because of this, the outer readout runs at a much lower rate than the inner one.

Each accepted event receives a number from a running event counter that wraps around. Every pulse carries the low bits of that number as a tag. When events far apart in number end up in the same readout pipeline, the tag still lets them be told apart. A pipeline window covers about 6 µs after its first trigger. With the minimum spacing, at most 7 more events can land in that window, so a 4-bit tag is enough.

A request is accepted only under two conditions: the minimum spacing since the last accepted trigger has elapsed, and every branch the request targets has its busy input low. A request that fails either condition is dropped and counted as rejected.

Top module: `split_trig_dist`

## Requirements
- R1: While reset is high and in the first cycle after it, both trigger outputs are low. The event number, the rejection counter and both tags are zero.
- R2: An accepted low-energy request (class code 1) makes a one-cycle pulse on the inner trigger one clock after the strobe is sampled. The outer trigger stays low.
- R3: An accepted high-energy request (class code 2) or outer request (class code 3) pulses the inner and outer triggers in the same cycle, one clock after the strobe is sampled.
- R4: An accepted request starts a spacing window of VETO_CYC = ceil(VETO_NS·1000 / CLK_PS) cycles (100 cycles by default). A request sampled 1 to VETO_CYC−1 cycles after an acceptance is rejected. A request sampled VETO_CYC cycles after it can be accepted.
- R5: A request is rejected if any branch it targets has its busy input high when the strobe is sampled. A low-energy request ignores the outer busy input.
- R6: The event number starts at 0 and increases by one on every accepted request. It wraps from its maximum value (0xFFFF at the default width) to 0.
- R7: Each pulse carries a tag equal to the low TAG_W bits of the number given to that event, valid in the pulse cycle. The first event after reset gets number 0. The event-number output shows the number the next event will receive.
- R8: A rejected request adds one to the rejection counter. An accepted request leaves the rejection counter unchanged.
- R9: A strobe with class code 0 is ignored: it produces no pulse, does not change either counter and does not start a spacing window.
- R10: Every trigger pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | 1 | Trigger request strobe, one cycle per request |
| req_class | input | 2 | Request class: 0 none, 1 low-energy, 2 high-energy, 3 outer |
| inner_busy | input | 1 | Inner branch is buffering and cannot take a trigger |
| outer_busy | input | 1 | Outer branch is buffering and cannot take a trigger |
| inner_trig | output | 1 | Inner branch trigger pulse |
| outer_trig | output | 1 | Outer branch trigger pulse |
| inner_tag | output | TAG_W | Event tag for the inner pulse |
| outer_tag | output | TAG_W | Event tag for the outer pulse |
| evnum | output | EVNUM_W | Number the next accepted event will receive |
| reject_cnt | output | CNT_W | Count of rejected requests, wrapping |

## Verification
The assertions assume the design is free to accept requests back to back, separated only by its spacing window. They also assume that the sampled class code and busy levels fully determine each decision, and that reset is held for at least two clocks. The stimulus changes the strobe, class and busy inputs only on falling edges and holds reset for several cycles. Busy levels are applied together with the strobe they should block, and the bench waits a full spacing window between table entries, so every decision depends only on that entry.

// File: rtl/stdist_pkg.sv
`timescale 1ns/1ps
package stdist_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_LOW   = 2'd1,
    CLS_HIGH  = 2'd2,
    CLS_OUTER = 2'd3
  } trig_class_e;

  localparam int BR_INNER = 0;
  localparam int BR_OUTER = 1;
  localparam int NUM_BR   = 2;

  // Branch mask for a class: bit BR_INNER, bit BR_OUTER.
  function automatic logic [NUM_BR-1:0] class_targets(input logic [1:0] cls);
    logic [NUM_BR-1:0] m;
    m = '0;
    case (trig_class_e'(cls))
      CLS_LOW:             m[BR_INNER] = 1'b1;
      CLS_HIGH, CLS_OUTER: m = '1;
      default:             m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/stdist_veto.sv
`timescale 1ns/1ps
module stdist_veto #(
  parameter int LOAD = 99,
  localparam int W = $clog2(LOAD + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= W'(LOAD);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/stdist_route.sv
`timescale 1ns/1ps
module stdist_route
  import stdist_pkg::*;
(
  input  logic              stb,
  input  logic [1:0]        cls,
  input  logic [NUM_BR-1:0] busy,
  input  logic              veto,
  output logic              accept,
  output logic              reject,
  output logic [NUM_BR-1:0] fire
);

  logic [NUM_BR-1:0] mask;
  logic              valid;
  logic              blocked;

  always_comb begin
    mask    = class_targets(cls);
    valid   = stb && (mask != '0);
    blocked = veto || ((mask & busy) != '0);
    accept  = valid && !blocked;
    reject  = valid && blocked;
    fire    = accept ? mask : '0;
  end

endmodule

// File: rtl/stdist_evtrack.sv
`timescale 1ns/1ps
module stdist_evtrack #(
  parameter int EVNUM_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               reject,
  output logic [EVNUM_W-1:0] evnum,
  output logic [CNT_W-1:0]   rej_cnt
);

  logic [EVNUM_W-1:0] ev_q;
  logic [CNT_W-1:0]   rj_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= '0;
      rj_q <= '0;
    end else begin
      if (accept) ev_q <= ev_q + 1'b1;
      if (reject) rj_q <= rj_q + 1'b1;
    end
  end

  assign evnum   = ev_q;
  assign rej_cnt = rj_q;

endmodule

// File: rtl/split_trig_dist.sv
`timescale 1ns/1ps
module split_trig_dist
  import stdist_pkg::*;
#(
  parameter int CLK_PS  = 8000,
  parameter int VETO_NS = 800,
  parameter int EVNUM_W = 16,
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_stb,
  input  logic [1:0]         req_class,
  input  logic               inner_busy,
  input  logic               outer_busy,
  output logic               inner_trig,
  output logic               outer_trig,
  output logic [TAG_W-1:0]   inner_tag,
  output logic [TAG_W-1:0]   outer_tag,
  output logic [EVNUM_W-1:0] evnum,
  output logic [CNT_W-1:0]   reject_cnt
);

  localparam int VETO_RAW = (VETO_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int VETO_CYC = (VETO_RAW < 1) ? 1 : VETO_RAW;

  logic [NUM_BR-1:0] busy_v;
  logic [NUM_BR-1:0] fire;
  logic              accept;
  logic              reject;
  logic              veto;

  logic [NUM_BR-1:0] trig_q;
  logic [TAG_W-1:0]  tag_q [NUM_BR];

  always_comb begin
    busy_v           = '0;
    busy_v[BR_INNER] = inner_busy;
    busy_v[BR_OUTER] = outer_busy;
  end

  stdist_route u_route (
    .stb    (req_stb),
    .cls    (req_class),
    .busy   (busy_v),
    .veto   (veto),
    .accept (accept),
    .reject (reject),
    .fire   (fire)
  );

  stdist_veto #(.LOAD(VETO_CYC - 1)) u_veto (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .active (veto)
  );

  stdist_evtrack #(.EVNUM_W(EVNUM_W), .CNT_W(CNT_W)) u_evtrack (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .reject  (reject),
    .evnum   (evnum),
    .rej_cnt (reject_cnt)
  );

  // Per-branch pulse and tag registers; the tag takes the number
  // assigned to this event, i.e. the counter value before increment.
  for (genvar b = 0; b < NUM_BR; b++) begin : g_branch
    always_ff @(posedge clk) begin
      if (rst) begin
        trig_q[b] <= 1'b0;
        tag_q[b]  <= '0;
      end else begin
        trig_q[b] <= fire[b];
        if (fire[b]) tag_q[b] <= evnum[TAG_W-1:0];
      end
    end
  end

  assign inner_trig = trig_q[BR_INNER];
  assign outer_trig = trig_q[BR_OUTER];
  assign inner_tag  = tag_q[BR_INNER];
  assign outer_tag  = tag_q[BR_OUTER];

endmodule

// File: rtl/stdist_chk.sv
`timescale 1ns/1ps
module stdist_chk
  import stdist_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int EVNUM_W  = 16,
  parameter int CNT_W    = 16,
  parameter int VETO_CYC = 100
) (
  input logic               clk,
  input logic               rst,
  input logic               req_stb,
  input logic [1:0]         req_class,
  input logic               inner_busy,
  input logic               outer_busy,
  input logic               inner_trig,
  input logic               outer_trig,
  input logic [TAG_W-1:0]   inner_tag,
  input logic [TAG_W-1:0]   outer_tag,
  input logic [EVNUM_W-1:0] evnum,
  input logic [CNT_W-1:0]   reject_cnt
);

  localparam int GW = 16;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                gap <= '1;
    else if (inner_trig)    gap <= '0;
    else if (gap != '1)     gap <= gap + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!inner_trig && !outer_trig && evnum == '0 && reject_cnt == '0));

  a_r2_low_skips_outer: assert property (@(posedge clk) disable iff (rst)
    outer_trig |-> ($past(req_class) != CLS_LOW));

  a_r3_outer_with_inner: assert property (@(posedge clk) disable iff (rst)
    outer_trig |-> inner_trig);

  a_r4_spacing: assert property (@(posedge clk) disable iff (rst)
    inner_trig |-> (32'(gap) >= 32'(VETO_CYC - 1)));

  a_r5_inner_free: assert property (@(posedge clk) disable iff (rst)
    inner_trig |-> !$past(inner_busy));

  a_r5_outer_free: assert property (@(posedge clk) disable iff (rst)
    outer_trig |-> !$past(outer_busy));

  a_r6_evnum_step: assert property (@(posedge clk) disable iff (rst)
    inner_trig |-> (evnum == EVNUM_W'($past(evnum) + 1'b1)));

  a_r7_inner_tag: assert property (@(posedge clk) disable iff (rst)
    inner_trig |-> (inner_tag == $past(evnum[TAG_W-1:0])));

  a_r7_outer_tag: assert property (@(posedge clk) disable iff (rst)
    outer_trig |-> (outer_tag == $past(evnum[TAG_W-1:0])));

  a_r8_reject_step: assert property (@(posedge clk) disable iff (rst)
    (reject_cnt == $past(reject_cnt)) || (reject_cnt == CNT_W'($past(reject_cnt) + 1'b1)));

  a_r9_none_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_stb && req_class == CLS_NONE) |=> !inner_trig);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    inner_trig |=> !inner_trig);

endmodule

bind split_trig_dist stdist_chk #(
  .TAG_W    (TAG_W),
  .EVNUM_W  (EVNUM_W),
  .CNT_W    (CNT_W),
  .VETO_CYC (VETO_CYC)
) u_chk (.*);

// File: tb/tb_split_trig_dist.sv
`timescale 1ns/1ps
module tb_split_trig_dist;

  localparam int VETO = 100;

  logic        clk = 1'b0;
  logic        rst;
  logic        stb;
  logic [1:0]  cls;
  logic        bi, bo;
  logic        it, ot;
  logic [3:0]  itag, otag;
  logic [15:0] ev;
  logic [15:0] rj;

  logic        w_stb;
  logic        w_it, w_ot;
  logic [3:0]  w_itag, w_otag;
  logic [4:0]  w_ev;
  logic [15:0] w_rj;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  split_trig_dist dut (
    .clk(clk), .rst(rst), .req_stb(stb), .req_class(cls),
    .inner_busy(bi), .outer_busy(bo),
    .inner_trig(it), .outer_trig(ot), .inner_tag(itag), .outer_tag(otag),
    .evnum(ev), .reject_cnt(rj)
  );

  split_trig_dist #(.VETO_NS(16), .EVNUM_W(5)) dut_w (
    .clk(clk), .rst(rst), .req_stb(w_stb), .req_class(2'd1),
    .inner_busy(1'b0), .outer_busy(1'b0),
    .inner_trig(w_it), .outer_trig(w_ot), .inner_tag(w_itag), .outer_tag(w_otag),
    .evnum(w_ev), .reject_cnt(w_rj)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {class[7:6], inner_busy[5], outer_busy[4], exp_inner[3], exp_outer[2], exp_reject[1], pad[0]}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 low, free
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 high, free
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 outer, free
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 low ignores outer busy
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 high blocked by outer busy
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 outer blocked by inner busy
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 low blocked by inner busy
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R9 none ignored
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 high again
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}   // R5 all busy
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] exp_ev;
    logic [15:0] exp_rj;
    rst = 1'b1; stb = 1'b0; cls = 2'd0; bi = 1'b0; bo = 1'b0; w_stb = 1'b0;
    exp_ev = '0; exp_rj = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 inner_trig", 32'(it), 0);
    chk("R1 outer_trig", 32'(ot), 0);
    chk("R1 evnum", 32'(ev), 0);
    chk("R1 reject_cnt", 32'(rj), 0);
    chk("R1 tags", 32'({itag, otag}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 quiet after release", 32'({it, ot}), 0);

    // Table walk: R2 R3 R5 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      cls = VEC[i][7:6]; bi = VEC[i][5]; bo = VEC[i][4]; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      chk($sformatf("R2/R3/R5/R9 inner vec %0d", i), 32'(it), 32'(VEC[i][3]));
      chk($sformatf("R2/R3/R5/R9 outer vec %0d", i), 32'(ot), 32'(VEC[i][2]));
      if (VEC[i][3]) begin
        chk($sformatf("R7 inner tag vec %0d", i), 32'(itag), 32'(exp_ev[3:0]));
        if (VEC[i][2])
          chk($sformatf("R7 outer tag vec %0d", i), 32'(otag), 32'(exp_ev[3:0]));
        exp_ev = exp_ev + 1'b1;
      end
      if (VEC[i][1]) exp_rj = exp_rj + 1'b1;
      chk($sformatf("R6 evnum vec %0d", i), 32'(ev), 32'(exp_ev));
      chk($sformatf("R8 reject_cnt vec %0d", i), 32'(rj), 32'(exp_rj));
      @(negedge clk);
      chk($sformatf("R10 pulse width vec %0d", i), 32'({it, ot}), 0);
      bi = 1'b0; bo = 1'b0;
      repeat (VETO) @(negedge clk);
    end

    // R4 spacing: accept, then a request VETO-1 cycles later is rejected,
    // one VETO cycles later is accepted.
    cls = 2'd1; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    chk("R4 first accepted", 32'(it), 1);
    exp_ev = exp_ev + 1'b1;
    repeat (VETO - 2) @(negedge clk);
    stb = 1'b1;
    @(negedge clk);
    chk("R4 early request dropped", 32'(it), 0);
    exp_rj = exp_rj + 1'b1;
    chk("R4 R8 early request counted", 32'(rj), 32'(exp_rj));
    @(negedge clk);
    stb = 1'b0;
    chk("R4 request at window end accepted", 32'(it), 1);
    exp_ev = exp_ev + 1'b1;
    chk("R4 R6 evnum after spacing", 32'(ev), 32'(exp_ev));
    chk("R8 accept leaves reject_cnt", 32'(rj), 32'(exp_rj));
    repeat (VETO) @(negedge clk);

    // R9 class none does not start a spacing window
    cls = 2'd0; stb = 1'b1;
    @(negedge clk);
    cls = 2'd1;
    @(negedge clk);
    stb = 1'b0;
    chk("R9 request right after none accepted", 32'(it), 1);
    exp_ev = exp_ev + 1'b1;
    chk("R9 counters unchanged by none", 32'(rj), 32'(exp_rj));
    repeat (VETO) @(negedge clk);

    // R6 wrap on narrow instance (5-bit number, 2-cycle spacing)
    for (int k = 0; k < 32; k++) begin
      w_stb = 1'b1;
      @(negedge clk);
      w_stb = 1'b0;
      @(negedge clk);
    end
    chk("R6 evnum wraps to zero", 32'(w_ev), 0);
    chk("R7 last tag before wrap", 32'(w_itag), 15);
    chk("R8 no rejects on narrow instance", 32'(w_rj), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule